// File: doc/BRIEF.md
# PLL Control Register with Guarded Writes

This block is the byte-wide control register of a clock generator. It stores eight control bits: the clock-monitor enable, the PLL power-on, the automatic bandwidth enable, the manual acquisition select, the fast wake-up enable, two reserved bits that are only stored, and the self-clock-mode enable. A write updates the register only when the write strobe and the address select are both high. The write takes effect on the rising clock edge. Reads are combinational from the stored bits.

Three of the bits have write locks driven by status inputs from the rest of the clock generator. The automatic bandwidth bit can also be forced to 1 by hardware. Three effective outputs go to the analog PLL and to the clock monitor: the PLL enable, the bandwidth select and the clock-monitor enable. Each one combines a stored bit with mode inputs, so an effective value can differ from the value read back.

Top module: `pll_ctl_reg`

## Requirements
- R1: After an asynchronous reset the read data is 8'hF1. The bits from bit 7 down to bit 0 are: monitor enable, PLL on, auto bandwidth, acquisition select, fast wake-up, reserved A, reserved B, self-clock enable.
- R2: A write with both `wr_en_i` and `sel_i` high loads `wdata_i` into every bit that is not locked, and the read data shows it after that edge. With either signal low, and `wait_pll_i` low, the read data does not change.
- R3: A write to bit 7 (monitor enable) is ignored while `selfclk_lock_i` is 1.
- R4: A write to bit 6 (PLL on) is ignored while `pll_in_use_i` is 1.
- R5: A write to bit 5 (auto bandwidth) is ignored while `wait_pll_i` is 1. On every clock edge where `wait_pll_i` is 1, bit 5 becomes 1, with or without a write.
- R6: Bits 4 to 0 take the written value on every accepted write, whatever the status inputs are.
- R7: When bit 5 is 0, `high_bw_o` equals bit 4 (1 selects the high-bandwidth filter). When bit 5 is 1, `high_bw_o` is the inverse of `near_target_i`, and bit 4 has no effect.
- R8: `pll_en_o` is 1 when bit 6 is 1 or `selfclk_act_i` is 1. `selfclk_act_i` does not change the read value of bit 6.
- R9: `clk_mon_en_o` is bit 7 gated off by `stop_i`. It is 0 whenever `stop_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| sel_i | input | 1 | Address match for this register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (stored bits) |
| selfclk_lock_i | input | 1 | Self-clock status; locks bit 7 |
| pll_in_use_i | input | 1 | PLL selected as system clock; locks bit 6 |
| wait_pll_i | input | 1 | PLL-in-wait status; locks and forces bit 5 |
| stop_i | input | 1 | Stop mode; disables the clock monitor |
| selfclk_act_i | input | 1 | Self-clock mode active; forces the PLL on |
| near_target_i | input | 1 | VCO near the target frequency (auto bandwidth) |
| pll_en_o | output | 1 | Effective PLL enable |
| high_bw_o | output | 1 | Effective bandwidth select, 1 = high |
| clk_mon_en_o | output | 1 | Effective clock-monitor enable |

## Verification
The bench sweeps every write byte against every combination of the three lock inputs and every strobe/select pairing. This exposes a lock wired to the wrong bit, or a lock that leaks onto neighbouring bits, as a bit that changes or fails to change. Running the force on bit 5 together with a write of 0 catches a design where the write wins over the force. After each write the bench sweeps the three mode inputs. A design that let the manual select through in automatic mode, or that fed the self-clock force back into the stored PLL bit, would give a wrong effective output or a wrong read value.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_MON  = 7;
  localparam int unsigned B_PLL  = 6;
  localparam int unsigned B_AUTO = 5;
  localparam int unsigned B_ACQ  = 4;
  localparam int unsigned B_FWK  = 3;
  localparam int unsigned B_RSVA = 2;
  localparam int unsigned B_RSVB = 1;
  localparam int unsigned B_SCE  = 0;
  localparam logic [REG_W-1:0] RST_VAL = 8'hF1;
endpackage

// File: rtl/pllc_bits.sv
module pllc_bits #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lock_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[i] <= RST[i];
      else if (set_i[i])            q_o[i] <= 1'b1;
      else if (we_i && !lock_i[i])  q_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/pllc_eff.sv
module pllc_eff (
  input  logic mon_en_i,
  input  logic pll_on_i,
  input  logic auto_bw_i,
  input  logic acq_i,
  input  logic selfclk_act_i,
  input  logic stop_i,
  input  logic near_target_i,
  output logic pll_en_o,
  output logic high_bw_o,
  output logic clk_mon_en_o
);
  always_comb begin
    pll_en_o     = pll_on_i | selfclk_act_i;
    // auto mode: acquire (high bw) until near target
    high_bw_o    = auto_bw_i ? ~near_target_i : acq_i;
    clk_mon_en_o = mon_en_i & ~stop_i;
  end
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pllc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             selfclk_lock_i,
  input  logic             pll_in_use_i,
  input  logic             wait_pll_i,
  input  logic             stop_i,
  input  logic             selfclk_act_i,
  input  logic             near_target_i,
  output logic             pll_en_o,
  output logic             high_bw_o,
  output logic             clk_mon_en_o
);
  logic [REG_W-1:0] lock, set_bits, ctrl_q;

  always_comb begin
    lock           = '0;
    lock[B_MON]    = selfclk_lock_i;
    lock[B_PLL]    = pll_in_use_i;
    lock[B_AUTO]   = wait_pll_i;
    set_bits       = '0;
    set_bits[B_AUTO] = wait_pll_i;
  end

  pllc_bits #(.W(REG_W), .RST(RST_VAL)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i & sel_i),
    .wdata_i (wdata_i),
    .lock_i  (lock),
    .set_i   (set_bits),
    .q_o     (ctrl_q)
  );

  assign rdata_o = ctrl_q;

  pllc_eff u_eff (
    .mon_en_i      (ctrl_q[B_MON]),
    .pll_on_i      (ctrl_q[B_PLL]),
    .auto_bw_i     (ctrl_q[B_AUTO]),
    .acq_i         (ctrl_q[B_ACQ]),
    .selfclk_act_i (selfclk_act_i),
    .stop_i        (stop_i),
    .near_target_i (near_target_i),
    .pll_en_o      (pll_en_o),
    .high_bw_o     (high_bw_o),
    .clk_mon_en_o  (clk_mon_en_o)
  );
endmodule

// File: rtl/pllc_chk.sv
module pllc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       sel_i,
  input logic [7:0] rdata_o,
  input logic       selfclk_lock_i,
  input logic       pll_in_use_i,
  input logic       wait_pll_i,
  input logic       stop_i,
  input logic       selfclk_act_i,
  input logic       near_target_i,
  input logic       pll_en_o,
  input logic       high_bw_o,
  input logic       clk_mon_en_o
);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i) && !wait_pll_i |=> $stable(rdata_o));
  assert_mon_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selfclk_lock_i |=> rdata_o[7] == $past(rdata_o[7]));
  assert_pll_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_in_use_i |=> rdata_o[6] == $past(rdata_o[6]));
  assert_auto_force_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_pll_i |=> rdata_o[5]);
  assert_pll_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selfclk_act_i |-> pll_en_o);
  assert_stop_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !clk_mon_en_o);
  assert_auto_bw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[5] |-> high_bw_o == !near_target_i);
endmodule

bind pll_ctl_reg pllc_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .sel_i          (sel_i),
  .rdata_o        (rdata_o),
  .selfclk_lock_i (selfclk_lock_i),
  .pll_in_use_i   (pll_in_use_i),
  .wait_pll_i     (wait_pll_i),
  .stop_i         (stop_i),
  .selfclk_act_i  (selfclk_act_i),
  .near_target_i  (near_target_i),
  .pll_en_o       (pll_en_o),
  .high_bw_o      (high_bw_o),
  .clk_mon_en_o   (clk_mon_en_o)
);

// File: tb/tb_pll_ctl_reg.sv
`timescale 1ns/1ps
module tb_pll_ctl_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       selfclk_lock_i = 1'b0, pll_in_use_i = 1'b0, wait_pll_i = 1'b0;
  logic       stop_i = 1'b0, selfclk_act_i = 1'b0, near_target_i = 1'b0;
  logic       pll_en_o, high_bw_o, clk_mon_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q;

  pll_ctl_reg dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #5_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    exp_q = 8'hF1;
    #12;
    chk(rdata_o, 8'hF1, "R1 reset value");
    chk({5'b0, pll_en_o, high_bw_o, clk_mon_en_o}, 8'h07, "R1 reset outputs");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int d = 0; d < 256; d++) begin
      for (int m = 0; m < 8; m++) begin
        for (int w = 0; w < 4; w++) begin
          @(negedge clk_i);
          wdata_i = d[7:0];
          {selfclk_lock_i, pll_in_use_i, wait_pll_i} = m[2:0];
          {wr_en_i, sel_i} = w[1:0];
          @(posedge clk_i);
          if (w == 3) begin
            if (!m[2]) exp_q[7] = d[7];
            if (!m[1]) exp_q[6] = d[6];
            if (!m[0]) exp_q[5] = d[5];
            exp_q[4:0] = d[4:0];
          end
          if (m[0]) exp_q[5] = 1'b1;
          #1;
          wr_en_i = 1'b0; sel_i = 1'b0; wait_pll_i = 1'b0;
          chk({7'b0, rdata_o[7]}, {7'b0, exp_q[7]}, "R3 monitor bit lock");
          chk({7'b0, rdata_o[6]}, {7'b0, exp_q[6]}, "R4 pll bit lock");
          chk({7'b0, rdata_o[5]}, {7'b0, exp_q[5]}, "R5 auto bit lock/force");
          chk({3'b0, rdata_o[4:0]}, {3'b0, exp_q[4:0]}, "R6 free bits");
          chk(rdata_o, exp_q, "R2 register value");
          for (int k = 0; k < 8; k++) begin
            {selfclk_act_i, stop_i, near_target_i} = k[2:0];
            #1;
            chk({7'b0, high_bw_o},
                {7'b0, exp_q[5] ? ~near_target_i : exp_q[4]}, "R7 bandwidth select");
            chk({7'b0, pll_en_o},
                {7'b0, exp_q[6] | selfclk_act_i}, "R8 pll enable");
            chk({7'b0, rdata_o[6]}, {7'b0, exp_q[6]}, "R8 readback unaffected");
            chk({7'b0, clk_mon_en_o},
                {7'b0, exp_q[7] & ~stop_i}, "R9 monitor gate");
          end
        end
      end
    end
    summary();
  end
endmodule